// File: doc/BRIEF.md
# Serial Controller Interrupt Identifier

This block sits beside the receive and transmit paths of a serial controller. It collects their status flags and the host's interrupt-enable settings, and turns them into one interrupt identification byte and one interrupt request line. When several sources are active at once, the most urgent one is reported.

The enable register lives here and is written through a strobe. The transmit-empty pending flag also lives here. It is set when the holding register drains, cleared by a holding-register load, cleared by reading the identification byte while that byte reports a transmit-empty event, and set again when its enable bit is turned back on while the holding register is empty. Receive status, the FIFO fill count, the trigger level, the character-timeout flag and the modem delta bits come from neighbouring blocks as plain levels.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the identification byte is 0x01, the request line is low and the enable register reads 0.
- R2: A write strobe loads bits 3:0 of the write data into the enable register, which is visible one clock later. Bits 7:4 of the write data are dropped.
- R3: Sources are ranked from highest to lowest as line status, character timeout, received data, transmit empty, modem status. Only the highest active source is reported.
- R4: A line-status interrupt (low nibble 0x6) needs enable bit 2 and at least one of the four error inputs: overrun, parity, framing or break.
- R5: A character timeout (low nibble 0xC) needs the timeout flag and enable bit 0.
- R6: A received-data interrupt (low nibble 0x4) needs enable bit 0 and data-ready. With FIFOs on, it also needs the fill count to be at or above the trigger level.
- R7: A transmit-empty interrupt (low nibble 0x2) needs enable bit 1 and the pending flag. The flag is set by the drain pulse and cleared by a holding-register load.
- R8: A read strobe taken while the low nibble is 0x2 clears the pending flag. A read taken while any other code is shown leaves the flag alone.
- R9: When a write changes enable bit 1, the pending flag becomes 1 if the new bit is 1 and the holding register is empty. Otherwise it becomes 0. A write that leaves bit 1 unchanged does not touch the flag.
- R10: A modem-status interrupt (low nibble 0x0) needs enable bit 3 and a nonzero modem delta.
- R11: Bits 7:6 of the identification byte read 11 while FIFOs are on and 00 while they are off. Bits 5:4 read 0.
- R12: The request line is a registered active-high level. It is high exactly when the low nibble is not 0x1, and it follows an input change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWrStb | input | 1 | Write strobe for the enable register |
| wrData | input | 8 | Write data for the enable register |
| idRdStb | input | 1 | Read strobe for the identification byte |
| holdLoadStb | input | 1 | Holding register was loaded |
| holdEmptySet | input | 1 | Holding register drained (one-cycle pulse) |
| holdEmpty | input | 1 | Holding register is empty (level) |
| lineErr | input | 4 | Overrun, parity, framing, break (bits 0..3) |
| dataReady | input | 1 | Received data available |
| fifoOn | input | 1 | FIFO mode enabled |
| rxCount | input | CNT_W | Receive FIFO fill count |
| trigLevel | input | CNT_W | Receive trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| modemDelta | input | 4 | Modem status change bits |
| enableReg | output | 4 | Current enable register |
| intId | output | 8 | Identification byte |
| irqOut | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle: that enable writes land, that an enabled line error wins the next cycle, that the FIFO flag bits follow the mode, that the request line stays low with all enables off, and the arm, disarm and read-clear updates of the pending flag. The bench scenarios are the only way to show the full priority ladder as sources drop away one by one, the FIFO threshold boundary, that a read showing another code leaves the flag alone, that rewriting enable bit 1 with the same value does nothing, and the exact one-clock latency of the request line.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W   = 4;
  localparam int LERR_W  = 4;
  localparam int MDLT_W  = 4;
  localparam int SRC_N   = 5;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_TXE   = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6,
    ID_TOUT  = 4'hC
  } idCode_e;

  // index 0 is the most urgent source
  function automatic idCode_e codeOf(input int idx);
    case (idx)
      0:       codeOf = ID_LINE;
      1:       codeOf = ID_TOUT;
      2:       codeOf = ID_RXD;
      3:       codeOf = ID_TXE;
      default: codeOf = ID_MODEM;
    endcase
  endfunction

  typedef struct packed {
    logic ierLoad;
    logic pendSet;
    logic pendClr;
  } ctrlStb_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWrStb,
  input  logic             wrTxEn,
  input  logic             idRdStb,
  input  logic             holdLoadStb,
  input  logic             holdEmptySet,
  input  logic             holdEmpty,
  input  logic             ierTxEn,
  input  logic             pendQ,
  input  idCode_e          curNib,
  output ctrlStb_t         stb
);
  logic bit1Chg;

  always_comb begin
    bit1Chg     = enWrStb && (wrTxEn != ierTxEn);
    stb.ierLoad = enWrStb;
    stb.pendSet = 1'b0;
    stb.pendClr = 1'b0;
    if (bit1Chg) begin
      stb.pendSet = wrTxEn && holdEmpty;
      stb.pendClr = !(wrTxEn && holdEmpty);
    end else if (holdLoadStb) begin
      stb.pendClr = 1'b1;
    end else if (idRdStb && curNib == ID_TXE) begin
      stb.pendClr = 1'b1;
    end else if (holdEmptySet && !pendQ) begin
      stb.pendSet = 1'b1;
    end
  end

  // R9: turning bit 1 on with an empty holding register arms the flag
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rstN)
    enWrStb && wrTxEn && !ierTxEn && holdEmpty |=> pendQ);

  // R9: turning bit 1 off drops the flag
  p_disarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    enWrStb && !wrTxEn && ierTxEn |=> !pendQ);

  // R8: reading while transmit empty is shown clears the flag
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    idRdStb && curNib == ID_TXE && !(enWrStb && wrTxEn != ierTxEn) |=> !pendQ);
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LERR_W-1:0] lineErr,
  input  logic              dataReady,
  input  logic              fifoOn,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              timeoutPend,
  input  logic [MDLT_W-1:0] modemDelta,
  output logic [IER_W-1:0]  ierQ,
  output logic              pendQ,
  output idCode_e           nibQ,
  output logic [DATA_W-1:0] intId,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - IER_W - 2;

  logic [SRC_N-1:0] reqVec;
  idCode_e          nxtNib;
  logic             fifoQ;
  logic             unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:IER_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ  <= '0;
      pendQ <= 1'b0;
    end else begin
      if (stb.ierLoad) ierQ <= wrData[IER_W-1:0];
      if (stb.pendClr)      pendQ <= 1'b0;
      else if (stb.pendSet) pendQ <= 1'b1;
    end
  end

  always_comb begin
    reqVec[0] = ierQ[2] && (|lineErr);
    reqVec[1] = ierQ[0] && timeoutPend;
    reqVec[2] = ierQ[0] && dataReady && (!fifoOn || rxCount >= trigLevel);
    reqVec[3] = ierQ[1] && pendQ;
    reqVec[4] = ierQ[3] && (|modemDelta);
  end

  always_comb begin
    nxtNib = ID_NONE;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (reqVec[i]) nxtNib = codeOf(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nibQ   <= ID_NONE;
      fifoQ  <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      nibQ   <= nxtNib;
      fifoQ  <= fifoOn;
      irqOut <= (nxtNib != ID_NONE);
    end
  end

  assign intId = {fifoQ, fifoQ, {PAD_W{1'b0}}, nibQ};

  // R2: an enable write is visible on the next cycle
  p_ier_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.ierLoad |=> ierQ == $past(wrData[IER_W-1:0]));

  // R4: an enabled line error is reported ahead of all others
  p_line_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    ierQ[2] && (|lineErr) |=> intId[3:0] == 4'h6);

  // R11: mode bits follow the FIFO flag
  p_fifo_bits_r11: assert property (@(posedge clk) disable iff (!rstN)
    fifoOn |=> intId[DATA_W-1 -: 2] == 2'b11);

  // R12: nothing enabled means no request
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    ierQ == '0 |=> !irqOut);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              idRdStb,
  input  logic              holdLoadStb,
  input  logic              holdEmptySet,
  input  logic              holdEmpty,
  input  logic [LERR_W-1:0] lineErr,
  input  logic              dataReady,
  input  logic              fifoOn,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              timeoutPend,
  input  logic [MDLT_W-1:0] modemDelta,
  output logic [IER_W-1:0]  enableReg,
  output logic [DATA_W-1:0] intId,
  output logic              irqOut
);
  ctrlStb_t stb;
  logic     pendQ;
  idCode_e  nibQ;

  uart_irq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enWrStb      (enWrStb),
    .wrTxEn       (wrData[1]),
    .idRdStb      (idRdStb),
    .holdLoadStb  (holdLoadStb),
    .holdEmptySet (holdEmptySet),
    .holdEmpty    (holdEmpty),
    .ierTxEn      (enableReg[1]),
    .pendQ        (pendQ),
    .curNib       (nibQ),
    .stb          (stb)
  );

  uart_irq_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .lineErr     (lineErr),
    .dataReady   (dataReady),
    .fifoOn      (fifoOn),
    .rxCount     (rxCount),
    .trigLevel   (trigLevel),
    .timeoutPend (timeoutPend),
    .modemDelta  (modemDelta),
    .ierQ        (enableReg),
    .pendQ       (pendQ),
    .nibQ        (nibQ),
    .intId       (intId),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enWrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic       idRdStb = 1'b0;
  logic       holdLoadStb = 1'b0;
  logic       holdEmptySet = 1'b0;
  logic       holdEmpty = 1'b0;
  logic [3:0] lineErr = '0;
  logic       dataReady = 1'b0;
  logic       fifoOn = 1'b0;
  logic [4:0] rxCount = '0;
  logic [4:0] trigLevel = '0;
  logic       timeoutPend = 1'b0;
  logic [3:0] modemDelta = '0;
  logic [3:0] enableReg;
  logic [7:0] intId;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rstN(rstN), .enWrStb(enWrStb), .wrData(wrData),
    .idRdStb(idRdStb), .holdLoadStb(holdLoadStb), .holdEmptySet(holdEmptySet),
    .holdEmpty(holdEmpty), .lineErr(lineErr), .dataReady(dataReady),
    .fifoOn(fifoOn), .rxCount(rxCount), .trigLevel(trigLevel),
    .timeoutPend(timeoutPend), .modemDelta(modemDelta),
    .enableReg(enableReg), .intId(intId), .irqOut(irqOut)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    tick(2);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wrIer(input logic [7:0] v);
    enWrStb = 1'b1; wrData = v;
    tick(1);
    enWrStb = 1'b0; wrData = '0;
  endtask

  task automatic pulseDrain();
    holdEmptySet = 1'b1; tick(1); holdEmptySet = 1'b0;
  endtask

  task automatic pulseLoad();
    holdLoadStb = 1'b1; tick(1); holdLoadStb = 1'b0;
  endtask

  task automatic pulseRead();
    idRdStb = 1'b1; tick(1); idRdStb = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; tick(3);
    chk("R1 id", intId, 8'h01);
    chk("R1 irq", {7'd0, irqOut}, 8'h00);
    chk("R1 enable", {4'd0, enableReg}, 8'h00);
    rstN = 1'b1; tick(1);
  endtask

  task automatic t_enable();
    wrIer(8'hFF);
    chk("R2 all bits", {4'd0, enableReg}, 8'h0F);
    wrIer(8'hA5);
    chk("R2 low nibble only", {4'd0, enableReg}, 8'h05);
    wrIer(8'hF0);
    chk("R2 upper bits dropped", {4'd0, enableReg}, 8'h00);
    settle();
  endtask

  task automatic t_line();
    lineErr = 4'b0100; settle();
    chk("R4 gated off", intId, 8'h01);
    wrIer(8'h04); settle();
    chk("R4 framing", intId, 8'h06);
    lineErr = 4'b0000; tick(1);
    chk("R12 drop id", intId, 8'h01);
    chk("R12 drop irq", {7'd0, irqOut}, 8'h00);
    lineErr = 4'b0001; tick(1);
    chk("R12 raise id", intId, 8'h06);
    chk("R12 raise irq", {7'd0, irqOut}, 8'h01);
    lineErr = 4'b1000; settle();
    chk("R4 break", intId, 8'h06);
    lineErr = 4'b0000; wrIer(8'h00); settle();
  endtask

  task automatic t_timeout();
    timeoutPend = 1'b1; wrIer(8'h04); settle();
    chk("R5 gated by bit0", intId, 8'h01);
    wrIer(8'h01); settle();
    chk("R5 timeout", intId, 8'h0C);
    lineErr = 4'b0010; wrIer(8'h05); settle();
    chk("R3 line over timeout", intId, 8'h06);
    lineErr = 4'b0000; timeoutPend = 1'b0; wrIer(8'h00); settle();
  endtask

  task automatic t_rxdata();
    wrIer(8'h01); dataReady = 1'b1; fifoOn = 1'b0; settle();
    chk("R6 no fifo", intId, 8'h04);
    chk("R11 mode bits off", {6'd0, intId[7:6]}, 8'h00);
    fifoOn = 1'b1; trigLevel = 5'd4; rxCount = 5'd3; settle();
    chk("R6 below trigger", intId, 8'hC1);
    rxCount = 5'd4; settle();
    chk("R6 at trigger", intId, 8'hC4);
    chk("R11 mode bits on", {6'd0, intId[7:6]}, 8'h03);
    trigLevel = 5'd14; rxCount = 5'd14; settle();
    chk("R6 at trigger 14", intId, 8'hC4);
    dataReady = 1'b0; settle();
    chk("R6 no data", intId, 8'hC1);
    dataReady = 1'b1; timeoutPend = 1'b1; settle();
    chk("R3 timeout over data", intId, 8'hCC);
    dataReady = 1'b0; timeoutPend = 1'b0; fifoOn = 1'b0;
    rxCount = '0; trigLevel = '0; wrIer(8'h00); settle();
  endtask

  task automatic t_txempty();
    wrIer(8'h02); pulseDrain(); settle();
    chk("R7 drain sets", intId, 8'h02);
    chk("R7 irq", {7'd0, irqOut}, 8'h01);
    pulseLoad(); settle();
    chk("R7 load clears", intId, 8'h01);
    pulseDrain(); wrIer(8'h03); dataReady = 1'b1; settle();
    chk("R3 data over tx", intId, 8'h04);
    dataReady = 1'b0; settle();
    chk("R3 tx after data", intId, 8'h02);
  endtask

  task automatic t_readclear();
    pulseRead(); settle();
    chk("R8 read clears", intId, 8'h01);
    holdEmpty = 1'b1;
    wrIer(8'h02); settle();
    chk("R9 same bit no rearm", intId, 8'h01);
    wrIer(8'h00); wrIer(8'h02); settle();
    chk("R9 rearm on rise", intId, 8'h02);
    holdEmpty = 1'b0;
    wrIer(8'h00); wrIer(8'h02); settle();
    chk("R9 no rearm while busy", intId, 8'h01);
    wrIer(8'h06); pulseDrain(); lineErr = 4'b0001; settle();
    chk("R3 line over tx", intId, 8'h06);
    pulseRead(); lineErr = 4'b0000; settle();
    chk("R8 other code keeps flag", intId, 8'h02);
    pulseLoad(); wrIer(8'h00); settle();
  endtask

  task automatic t_modem();
    modemDelta = 4'b0100; settle();
    chk("R10 gated off", intId, 8'h01);
    wrIer(8'h08); settle();
    chk("R10 modem", intId, 8'h00);
    chk("R10 irq", {7'd0, irqOut}, 8'h01);
    modemDelta = 4'b0000; settle();
    chk("R10 no delta", intId, 8'h01);
    wrIer(8'h00); settle();
  endtask

  initial begin
    t_reset();
    t_enable();
    t_line();
    t_timeout();
    t_rxdata();
    t_txempty();
    t_readclear();
    t_modem();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule